// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command-register state machine of a NOR-style flash memory model with 16-bit word addressing. It watches single-cycle write strobes on an address/data bus and decodes unlock-prefixed command sequences. The decoded commands are reset, identification read, word program, whole-array erase, sector erase, fast-program (bypass) mode, and erase pause and continue. It keeps the operating mode and queues sectors for erase while a restartable time-out window is open. It also drives an external program/erase engine through a start pulse with operation fields, a pause level, an abort pulse and a completion input.

Sectors are found by comparing the address against a parameter list of ascending sector start addresses. By default there are eleven sectors with small sectors at the bottom. The same lookup serves the erase queue, the check that blocks a paused-erase program into an erasing sector, and the protection flag returned in identification mode. The erase window length is a parameter counted in clock cycles. The storage array, pulse timing and byte-wide bus mode are outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and after `rst_n` is asserted at any time, `mode` is 0 (read), `erase_set` is zero, and `op_start`, `eng_hold` and `eng_abort` are low. The `mode` codes are: 0 read, 1 ID, 2 bypass, 3 programming, 4 bypass programming, 5 erase window, 6 erasing, 7 erase paused, 8 programming while paused.
- R2: In modes 0 and 1, a command starts with AAh written to 555h and then 55h written to 2AAh. Only address bits 10:0 and data bits 7:0 are compared. Any other write in place of an expected unlock write, or an unknown command byte, returns the decoder to its idle step without changing `mode`.
- R3: Unlock followed by A0h at 555h arms a program, and the next write of any value is the target. In the cycle after that write, `op_start` is high for exactly one cycle, `op_erase` is 0, `op_addr` and `op_data` carry the target, and `mode` is 3. Writes are ignored in mode 3. `eng_done` returns `mode` to 0.
- R4: Unlock, 80h at 555h, unlock, 10h at 555h starts an erase at once: `op_start` high, `op_erase` 1, every `erase_set` bit set, and `mode` 6.
- R5: Unlock, 80h, unlock, then 30h at any address sets `mode` to 5 with only that address's sector bit set in `erase_set`. Sector i covers word addresses from base i up to base i+1 minus 1. The default bases are 00000h, 02000h, 03000h, 04000h, 08000h, 10000h, 18000h, 20000h, 28000h, 30000h and 38000h. Each further 30h write adds its sector and restarts the window. The erase starts (`op_start`, `op_erase` 1, `mode` 6) ERASE_TMO cycles after the last 30h write.
- R6: In mode 5, any write other than 30h or B0h sets `mode` to 0 and clears `erase_set`, and nothing starts.
- R7: Unlock then 20h at 555h enters mode 2. There, A0h followed by any write starts a program and enters mode 4, and `eng_done` returns to mode 2. F0h, unlock writes and other bytes are ignored. 90h followed by 00h is the only exit, to mode 0. 90h followed by anything else stays in mode 2.
- R8: B0h in mode 6 enters mode 7. B0h in mode 5 enters mode 7 and issues the erase start in the same cycle. `eng_hold` is high in modes 7 and 8. A 30h write in mode 7 returns to mode 6 with `eng_hold` low. Extra B0h writes in mode 7 and extra 30h writes in mode 6 change nothing.
- R9: In mode 7, unlock, A0h, then a target outside `erase_set` starts a program and enters mode 8, and `eng_done` returns to mode 7. A target inside `erase_set` is rejected and stays in mode 7. Other commands, such as ID entry, are ignored.
- R10: F0h in modes 0, 1, 5, 6 and 7 sets `mode` to 0 and clears `erase_set`. In modes 6 and 7 it also pulses `eng_abort` for one cycle.
- R11: Unlock then 90h at 555h enters mode 1. In mode 1, `id_q` depends on `rd_addr` bits 7:0. Offset 00h returns MFR_ID, 01h returns DEV_ID, and 02h returns bit 0 equal to the `prot_mask` bit of the sector holding `rd_addr`. Every other offset, and every read outside mode 1, returns 0.
- R12: `eng_done` in mode 6 sets `mode` to 0 and clears `erase_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Data of the write |
| rd_addr | input | AW | Read address for identification data |
| prot_mask | input | NSEC | Per-sector protection flags |
| eng_done | input | 1 | Engine reports completion |
| mode | output | 4 | Current operating mode code |
| id_q | output | DW | Identification read data |
| op_start | output | 1 | One-cycle engine start |
| op_erase | output | 1 | Kind of last start: 1 erase, 0 program |
| op_addr | output | AW | Program target address |
| op_data | output | DW | Program data |
| erase_set | output | NSEC | Sectors queued or being erased |
| eng_hold | output | 1 | Erase paused |
| eng_abort | output | 1 | One-cycle engine abort |

## Verification
The assertions check several rules on every cycle. A busy program ignores all writes. An abort always lands in read mode with an empty erase set. Starts never come on consecutive cycles, and every start seen in an erase mode is an erase. A program started while paused never targets a queued sector, and the window counter reloads and stays in range. The bench's scenarios are needed for the rest: the exact unlock orders, the erase start landing ERASE_TMO cycles after the last queued sector, the dropped queue, the bypass exit pair, the ignored repeats of pause and continue, and the identification read values.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    M_READ  = 4'd0,
    M_ID    = 4'd1,
    M_BYP   = 4'd2,
    M_PROG  = 4'd3,
    M_BPROG = 4'd4,
    M_ERWIN = 4'd5,
    M_ERASE = 4'd6,
    M_SUSP  = 4'd7,
    M_SPROG = 4'd8
  } mode_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3, SQ_BX
  } seq_t;

  localparam logic [7:0] K_UNL1  = 8'hAA;
  localparam logic [7:0] K_UNL2  = 8'h55;
  localparam logic [7:0] K_PGM   = 8'hA0;
  localparam logic [7:0] K_SETUP = 8'h80;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_AUTO  = 8'h90;
  localparam logic [7:0] K_BYP   = 8'h20;
  localparam logic [7:0] K_SUSP  = 8'hB0;
  localparam logic [7:0] K_RST   = 8'hF0;
  localparam logic [7:0] K_BXIT  = 8'h00;
  localparam logic [10:0] A_UNL1 = 11'h555;
  localparam logic [10:0] A_UNL2 = 11'h2AA;
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int AW = 18,
  parameter int NSEC = 11,
  parameter logic [NSEC*AW-1:0] BASES = '0
) (
  input  logic [AW-1:0]   addr,
  output logic [NSEC-1:0] hit
);
  logic [NSEC:0] ge;
  assign ge[NSEC] = 1'b0;

  for (genvar i = 0; i < NSEC; i++) begin : g_cmp
    assign ge[i]  = (addr >= BASES[i*AW +: AW]);
    assign hit[i] = ge[i] & ~ge[i+1];
  end
endmodule

// File: rtl/flash_erase_window.sv
module flash_erase_window #(
  parameter int TMO = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TMO + 1);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (restart)                 cnt_n = CW'(TMO - 1);
    else if (run && cnt_q != '0) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expire = run && (cnt_q == '0);

  assert_window_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == CW'(TMO - 1)));
  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO - 1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 18,
  parameter int NSEC = 11,
  parameter int DW = 16,
  parameter int ERASE_TMO = 1000,
  parameter logic [DW-1:0] MFR_ID = 16'h0037,
  parameter logic [DW-1:0] DEV_ID = 16'h22C4,
  parameter logic [NSEC*AW-1:0] SEC_BASE = {
    18'h38000, 18'h30000, 18'h28000, 18'h20000, 18'h18000, 18'h10000,
    18'h08000, 18'h04000, 18'h03000, 18'h02000, 18'h00000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NSEC-1:0] prot_mask,
  input  logic            eng_done,
  output logic [3:0]      mode,
  output logic [DW-1:0]   id_q,
  output logic            op_start,
  output logic            op_erase,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic [NSEC-1:0] erase_set,
  output logic            eng_hold,
  output logic            eng_abort
);
  mode_t mode_q, mode_n;
  seq_t  seq_q, seq_n;
  logic [NSEC-1:0] set_q, set_n, wr_hit, rd_hit;
  logic start_q, start_n, erase_q, erase_n, abort_q, abort_n;
  logic ld_op, restart, win_run, win_exp;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [7:0] wd;
  logic at_555, is_u1, is_u2;

  assign wd     = wr_data[7:0];
  assign at_555 = (wr_addr[10:0] == A_UNL1);
  assign is_u1  = at_555 && (wd == K_UNL1);
  assign is_u2  = (wr_addr[10:0] == A_UNL2) && (wd == K_UNL2);

  flash_sector_map #(.AW(AW), .NSEC(NSEC), .BASES(SEC_BASE)) u_map_wr (
    .addr(wr_addr), .hit(wr_hit));
  flash_sector_map #(.AW(AW), .NSEC(NSEC), .BASES(SEC_BASE)) u_map_rd (
    .addr(rd_addr), .hit(rd_hit));

  assign win_run = (mode_q == M_ERWIN) && !wr_en;
  flash_erase_window #(.TMO(ERASE_TMO)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(win_run), .expire(win_exp));

  always_comb begin
    mode_n = mode_q; seq_n = seq_q; set_n = set_q;
    start_n = 1'b0; erase_n = erase_q; abort_n = 1'b0;
    restart = 1'b0; ld_op = 1'b0;
    case (mode_q)
      M_READ, M_ID: if (wr_en) begin
        seq_n = SQ_IDLE;
        if (seq_q == SQ_PGM) begin
          start_n = 1'b1; erase_n = 1'b0; ld_op = 1'b1; mode_n = M_PROG;
        end else if (wd == K_RST) begin
          mode_n = M_READ;
        end else begin
          case (seq_q)
            SQ_IDLE: if (is_u1) seq_n = SQ_U1;
            SQ_U1:   if (is_u2) seq_n = SQ_U2;
            SQ_U2: if (at_555) begin
              if (wd == K_PGM)        seq_n  = SQ_PGM;
              else if (wd == K_AUTO)  mode_n = M_ID;
              else if (wd == K_BYP)   mode_n = M_BYP;
              else if (wd == K_SETUP) seq_n  = SQ_E1;
            end
            SQ_E1: if (is_u1) seq_n = SQ_E2;
            SQ_E2: if (is_u2) seq_n = SQ_E3;
            SQ_E3: begin
              if (at_555 && wd == K_CHIP) begin
                start_n = 1'b1; erase_n = 1'b1; set_n = '1; mode_n = M_ERASE;
              end else if (wd == K_SECT) begin
                set_n = wr_hit; restart = 1'b1; mode_n = M_ERWIN;
              end
            end
            default: ;
          endcase
        end
      end
      M_BYP: if (wr_en) begin
        seq_n = SQ_IDLE;
        case (seq_q)
          SQ_IDLE: begin
            if (wd == K_PGM)       seq_n = SQ_PGM;
            else if (wd == K_AUTO) seq_n = SQ_BX;
          end
          SQ_PGM: begin
            start_n = 1'b1; erase_n = 1'b0; ld_op = 1'b1; mode_n = M_BPROG;
          end
          SQ_BX: if (wd == K_BXIT) mode_n = M_READ;
          default: ;
        endcase
      end
      M_ERWIN: begin
        if (wr_en) begin
          if (wd == K_SECT) begin
            set_n = set_q | wr_hit; restart = 1'b1;
          end else if (wd == K_SUSP) begin
            start_n = 1'b1; erase_n = 1'b1; mode_n = M_SUSP;
          end else begin
            set_n = '0; mode_n = M_READ;
          end
        end else if (win_exp) begin
          start_n = 1'b1; erase_n = 1'b1; mode_n = M_ERASE;
        end
      end
      M_ERASE: begin
        if (eng_done) begin
          mode_n = M_READ; set_n = '0;
        end else if (wr_en) begin
          if (wd == K_SUSP) mode_n = M_SUSP;
          else if (wd == K_RST) begin
            abort_n = 1'b1; mode_n = M_READ; set_n = '0;
          end
        end
      end
      M_SUSP: if (wr_en) begin
        seq_n = SQ_IDLE;
        if (seq_q == SQ_PGM) begin
          if ((wr_hit & set_q) == '0) begin
            start_n = 1'b1; erase_n = 1'b0; ld_op = 1'b1; mode_n = M_SPROG;
          end
        end else if (wd == K_RST) begin
          abort_n = 1'b1; mode_n = M_READ; set_n = '0;
        end else begin
          case (seq_q)
            SQ_IDLE: begin
              if (wd == K_SECT) mode_n = M_ERASE;
              else if (is_u1)   seq_n  = SQ_U1;
            end
            SQ_U1: if (is_u2) seq_n = SQ_U2;
            SQ_U2: if (at_555 && wd == K_PGM) seq_n = SQ_PGM;
            default: ;
          endcase
        end
      end
      M_PROG:  if (eng_done) mode_n = M_READ;
      M_BPROG: if (eng_done) mode_n = M_BYP;
      M_SPROG: if (eng_done) mode_n = M_SUSP;
      default: begin
        mode_n = M_READ; seq_n = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_READ;
      seq_q   <= SQ_IDLE;
      set_q   <= '0;
      start_q <= 1'b0;
      erase_q <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      mode_q  <= mode_n;
      seq_q   <= seq_n;
      set_q   <= set_n;
      start_q <= start_n;
      erase_q <= erase_n;
      abort_q <= abort_n;
      if (ld_op) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  always_comb begin
    id_q = '0;
    if (mode_q == M_ID) begin
      case (rd_addr[7:0])
        8'h00:   id_q = MFR_ID;
        8'h01:   id_q = DEV_ID;
        8'h02:   id_q = DW'(|(rd_hit & prot_mask));
        default: id_q = '0;
      endcase
    end
  end

  assign mode      = mode_q;
  assign op_start  = start_q;
  assign op_erase  = erase_q;
  assign op_addr   = addr_q;
  assign op_data   = data_q;
  assign erase_set = set_q;
  assign eng_abort = abort_q;
  assign eng_hold  = (mode_q == M_SUSP) || (mode_q == M_SPROG);

  assert_prog_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PROG && !eng_done) |=> (mode_q == M_PROG));
  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  assert_erase_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && (mode_q == M_ERASE || mode_q == M_SUSP)) |-> op_erase);
  assert_susp_prog_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && mode_q == M_SPROG) |-> (($past(wr_hit) & erase_set) == '0));
  assert_abort_to_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (mode_q == M_READ && erase_set == '0));
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int TMO = 12;
  localparam logic [15:0] MFR = 16'h0037;
  localparam logic [15:0] DEV = 16'h22C4;
  localparam int BASES [11] = '{'h0, 'h2000, 'h3000, 'h4000, 'h8000, 'h10000,
                                'h18000, 'h20000, 'h28000, 'h30000, 'h38000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [17:0] rd_addr = '0;
  logic [10:0] prot_mask = 11'h010;
  logic eng_done = 1'b0;
  logic [3:0] mode;
  logic [15:0] id_q, op_data;
  logic op_start, op_erase, eng_hold, eng_abort;
  logic [17:0] op_addr;
  logic [10:0] erase_set;

  int total = 0;
  int bad = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ERASE_TMO(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prot_mask(prot_mask), .eng_done(eng_done), .mode(mode),
    .id_q(id_q), .op_start(op_start), .op_erase(op_erase), .op_addr(op_addr),
    .op_data(op_data), .erase_set(erase_set), .eng_hold(eng_hold), .eng_abort(eng_abort));

  function automatic int sec_of(logic [17:0] a);
    int s = 0;
    for (int i = 0; i < 11; i++) if (int'(a) >= BASES[i]) s = i;
    return s;
  endfunction

  // behavioural reference model
  int m_mode, m_step, m_left;
  logic [10:0] m_set;
  bit m_start, m_erase, m_abort;
  logic [17:0] m_addr;
  logic [15:0] m_data;

  always @(posedge clk) begin
    int d;
    bit a5, u1, u2;
    logic [10:0] hm;
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_left = 0; m_set = '0;
      m_start = 0; m_erase = 0; m_abort = 0; m_addr = '0; m_data = '0;
    end else begin
      d  = int'(wr_data[7:0]);
      a5 = (wr_addr[10:0] == 11'h555);
      u1 = a5 && d == 'hAA;
      u2 = (wr_addr[10:0] == 11'h2AA) && d == 'h55;
      hm = 11'(1) << sec_of(wr_addr);
      m_start = 0; m_abort = 0;
      if (m_mode == 0 || m_mode == 1) begin
        if (wr_en) begin
          if (m_step == 3) begin
            m_start = 1; m_erase = 0; m_addr = wr_addr; m_data = wr_data; m_mode = 3; m_step = 0;
          end else if (d == 'hF0) begin m_mode = 0; m_step = 0; end
          else if (m_step == 0) m_step = u1 ? 1 : 0;
          else if (m_step == 1) m_step = u2 ? 2 : 0;
          else if (m_step == 2) begin
            m_step = 0;
            if (a5 && d == 'hA0) m_step = 3;
            else if (a5 && d == 'h90) m_mode = 1;
            else if (a5 && d == 'h20) m_mode = 2;
            else if (a5 && d == 'h80) m_step = 4;
          end
          else if (m_step == 4) m_step = u1 ? 5 : 0;
          else if (m_step == 5) m_step = u2 ? 6 : 0;
          else begin
            m_step = 0;
            if (a5 && d == 'h10) begin m_start = 1; m_erase = 1; m_set = '1; m_mode = 6; end
            else if (d == 'h30) begin m_set = hm; m_left = TMO; m_mode = 5; end
          end
        end
      end else if (m_mode == 2) begin
        if (wr_en) begin
          if (m_step == 3) begin
            m_start = 1; m_erase = 0; m_addr = wr_addr; m_data = wr_data; m_mode = 4; m_step = 0;
          end else if (m_step == 7) begin m_step = 0; if (d == 0) m_mode = 0; end
          else if (d == 'hA0) m_step = 3;
          else if (d == 'h90) m_step = 7;
        end
      end else if (m_mode == 5) begin
        if (wr_en) begin
          if (d == 'h30) begin m_set = m_set | hm; m_left = TMO; end
          else if (d == 'hB0) begin m_start = 1; m_erase = 1; m_mode = 7; end
          else begin m_set = '0; m_mode = 0; end
        end else begin
          m_left--;
          if (m_left <= 0) begin m_start = 1; m_erase = 1; m_mode = 6; end
        end
      end else if (m_mode == 6) begin
        if (eng_done) begin m_mode = 0; m_set = '0; end
        else if (wr_en && d == 'hB0) m_mode = 7;
        else if (wr_en && d == 'hF0) begin m_abort = 1; m_mode = 0; m_set = '0; end
      end else if (m_mode == 7) begin
        if (wr_en) begin
          if (m_step == 3) begin
            m_step = 0;
            if ((hm & m_set) == 0) begin
              m_start = 1; m_erase = 0; m_addr = wr_addr; m_data = wr_data; m_mode = 8;
            end
          end else if (d == 'hF0) begin m_step = 0; m_abort = 1; m_mode = 0; m_set = '0; end
          else if (m_step == 0) begin
            if (d == 'h30) m_mode = 6; else if (u1) m_step = 1;
          end
          else if (m_step == 1) m_step = u2 ? 2 : 0;
          else m_step = (a5 && d == 'hA0) ? 3 : 0;
        end
      end else if (eng_done) begin
        if (m_mode == 3) m_mode = 0;
        else if (m_mode == 4) m_mode = 2;
        else if (m_mode == 8) m_mode = 7;
      end
    end
  end

  function automatic logic [15:0] exp_id();
    if (m_mode != 1) return 16'h0;
    case (rd_addr[7:0])
      8'h00: return MFR;
      8'h01: return DEV;
      8'h02: return {15'h0, prot_mask[sec_of(rd_addr)]};
      default: return 16'h0;
    endcase
  endfunction

  // compare design against model on every clock
  always @(posedge clk) begin
    #1;
    if (rst_n && !timed_out) begin
      total++;
      if (int'(mode) != m_mode) begin
        bad++; $display("FAIL R2 model mode act=%0d exp=%0d t=%0t", mode, m_mode, $time);
      end else if (op_start != m_start || (m_start && op_erase != m_erase)) begin
        bad++; $display("FAIL R3 model start/kind act=%0b/%0b exp=%0b/%0b", op_start, op_erase, m_start, m_erase);
      end else if (m_start && !m_erase && (op_addr != m_addr || op_data != m_data)) begin
        bad++; $display("FAIL R3 model target act=%h/%h exp=%h/%h", op_addr, op_data, m_addr, m_data);
      end else if (erase_set != m_set) begin
        bad++; $display("FAIL R5 model set act=%h exp=%h", erase_set, m_set);
      end else if (eng_hold != (m_mode == 7 || m_mode == 8)) begin
        bad++; $display("FAIL R8 model hold act=%0b exp mode=%0d", eng_hold, m_mode);
      end else if (eng_abort != m_abort) begin
        bad++; $display("FAIL R10 model abort act=%0b exp=%0b", eng_abort, m_abort);
      end else if (id_q != exp_id()) begin
        bad++; $display("FAIL R11 model id act=%h exp=%h", id_q, exp_id());
      end
    end
  end

  task automatic ck(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unl();
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55);
  endtask

  task automatic sect_erase(logic [17:0] a);
    unl(); wr(18'h555, 16'h80); unl(); wr(a, 16'h30);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    idle(3); rst_n = 1'b1; idle(2);
    ck("R1 reset mode", mode, 0);
    ck("R1 reset set", erase_set, 0);
    ck("R1 reset pulses", {op_start, eng_hold, eng_abort}, 0);

    wr(18'h555, 16'hAA); wr(18'h123, 16'h55); wr(18'h555, 16'hA0); wr(18'h4000, 16'h0);
    ck("R2 broken unlock no start", mode, 0);
    unl(); wr(18'h555, 16'h77);
    ck("R2 unknown command", mode, 0);

    wr(18'h3F555, 16'hFFAA); wr(18'h3F2AA, 16'h0055); wr(18'h555, 16'hA0);
    wr(18'h12345, 16'hBEEF);
    ck("R3 start", op_start, 1);
    ck("R3 kind", op_erase, 0);
    ck("R3 addr", op_addr, 'h12345);
    ck("R3 data", op_data, 'hBEEF);
    ck("R3 busy", mode, 3);
    wr(18'h555, 16'hF0);
    ck("R3 write ignored when busy", mode, 3);
    done_pulse();
    ck("R3 done", mode, 0);

    unl(); wr(18'h555, 16'h90);
    ck("R11 id mode", mode, 1);
    rd_addr = 18'h0; idle(1); ck("R11 mfr", id_q, MFR);
    rd_addr = 18'h1; idle(1); ck("R11 dev", id_q, DEV);
    rd_addr = 18'h08002; idle(1); ck("R11 protected", id_q, 1);
    rd_addr = 18'h00002; idle(1); ck("R11 unprotected", id_q, 0);
    wr(18'h0, 16'hF0);
    ck("R10 reset from id", mode, 0);
    rd_addr = 18'h0; idle(1); ck("R11 id outside mode", id_q, 0);

    unl(); wr(18'h555, 16'h80); unl(); wr(18'h555, 16'h10);
    ck("R4 chip start", {op_start, op_erase}, 3);
    ck("R4 chip set", erase_set, 'h7FF);
    ck("R4 erasing", mode, 6);
    wr(18'h0, 16'hB0);
    ck("R8 pause", {mode, eng_hold}, {4'd7, 1'b1});
    wr(18'h0, 16'hB0);
    ck("R8 repeat pause ignored", mode, 7);
    wr(18'h0, 16'h30);
    ck("R8 continue", {mode, eng_hold}, {4'd6, 1'b0});
    wr(18'h0, 16'h30);
    ck("R8 repeat continue ignored", mode, 6);
    done_pulse();
    ck("R12 done", mode, 0);
    ck("R12 set cleared", erase_set, 0);

    sect_erase(18'h02100);
    ck("R5 window", mode, 5);
    ck("R5 first sector", erase_set, 'h002);
    idle(4);
    wr(18'h20000, 16'h30);
    ck("R5 added sector", erase_set, 'h082);
    idle(TMO - 1);
    ck("R5 still waiting", {mode, op_start}, {4'd5, 1'b0});
    idle(1);
    ck("R5 erase started", {mode, op_start, op_erase}, {4'd6, 2'b11});
    wr(18'h0, 16'hB0);
    ck("R8 paused", mode, 7);
    unl(); wr(18'h555, 16'hA0); wr(18'h02200, 16'h1111);
    ck("R9 reject erasing sector", {mode, op_start}, {4'd7, 1'b0});
    unl(); wr(18'h555, 16'h90);
    ck("R9 id ignored when paused", mode, 7);
    unl(); wr(18'h555, 16'hA0); wr(18'h30000, 16'h2222);
    ck("R9 program while paused", {mode, op_start, op_erase, eng_hold}, {4'd8, 1'b1, 1'b0, 1'b1});
    done_pulse();
    ck("R9 back to paused", mode, 7);
    wr(18'h0, 16'hF0);
    ck("R10 abort", {mode, eng_abort}, {4'd0, 1'b1});
    ck("R10 set cleared", erase_set, 0);

    sect_erase(18'h00010);
    wr(18'h555, 16'hAA);
    ck("R6 dropped", {mode, op_start}, {4'd0, 1'b0});
    ck("R6 set cleared", erase_set, 0);

    sect_erase(18'h00010);
    wr(18'h0, 16'hB0);
    ck("R8 pause in window starts", {mode, op_start, op_erase}, {4'd7, 2'b11});
    wr(18'h0, 16'h30);
    ck("R8 continue after window", mode, 6);
    wr(18'h0, 16'hF0);
    ck("R10 abort erasing", {mode, eng_abort}, {4'd0, 1'b1});

    unl(); wr(18'h555, 16'h20);
    ck("R7 bypass", mode, 2);
    wr(18'h0, 16'hA0); wr(18'h00100, 16'h1234);
    ck("R7 bypass program", {mode, op_start}, {4'd4, 1'b1});
    ck("R7 bypass target", op_addr, 'h100);
    done_pulse();
    ck("R7 back to bypass", mode, 2);
    wr(18'h0, 16'hF0);
    ck("R7 reset ignored", mode, 2);
    unl();
    ck("R7 unlock ignored", mode, 2);
    wr(18'h0, 16'h90); wr(18'h0, 16'h55);
    ck("R7 bad exit stays", mode, 2);
    wr(18'h0, 16'h90); wr(18'h7, 16'h00);
    ck("R7 exit", mode, 0);

    unl(); wr(18'h555, 16'hA0); wr(18'h00200, 16'h5A5A);
    ck("R3 busy before reset", mode, 3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    ck("R1 reset aborts", mode, 0);
    idle(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        #400000;
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule